// File: doc/BRIEF.md
# Vectored Interrupt Controller for a Small 8-bit Core

This block collects interrupt events for a small 8-bit processor core and decides when the core should leave its program and run a service routine. There are three event sources. The first is a falling edge on an asynchronous, active-low external pin. The second is a one-cycle overflow strobe from a timer. The third is a one-cycle end-of-conversion strobe from an A/D converter. An event is always latched in a request flag, even when its enable is off. A latched request is serviced only when its own enable and the master enable are both set.

The flags, the per-source enables and the master enable share one 8-bit control register. Software reaches it through a simple write strobe and a combinational read port. When a request is accepted, the block sends the core a one-cycle take strobe together with a fixed vector address. The core pushes its program counter and jumps to that vector. In the same cycle the block clears the master enable and the serviced flag, so routines nest only when software sets the master enable again. The core marks instruction boundaries and reports whether its stack is full. No request is accepted while the stack is full. A return-from-interrupt strobe from the core becomes a pop command one cycle later.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the register reads 0x00 and irq_take and pc_pop are 0.
- R2: Bit 0 of the register is the master enable. Bits 1, 2 and 3 are the enables for the external, timer and A/D sources. Bits 4, 5 and 6 are the flags for the same three sources. Bit 7 ignores writes and always reads 0. A write takes effect on the next clock edge.
- R3: When the master enable is 0, no request is accepted, whatever the source enables and flags hold.
- R4: A flag is set by its source event whatever the value of its enable. The timer and A/D events are one-cycle strobes. The external event is a falling edge on ext_int_n, seen after a two-stage synchronizer. A pin held low does not set the flag again.
- R5: A request is taken only if both its flag and its enable are 1. When several requests qualify, the external source wins over the timer, and the timer wins over the A/D source. The vectors are 0x004 for external, 0x008 for timer and 0x00C for A/D, presented on irq_vector with a one-cycle irq_take pulse.
- R6: Taking a request clears the master enable and only the serviced flag. All other flags and enables keep their values, and irq_take lasts exactly one cycle.
- R7: Requests left pending are taken in priority order each time software sets the master enable again.
- R8: While stack_full is 1, no request is accepted. The request is then taken at the first boundary after stack_full falls.
- R9: A request is accepted only in a cycle where insn_bound is 1.
- R10: A reti strobe produces a one-cycle pc_pop pulse in the following cycle.
- R11: If an event and a software write reach the same flag in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_int_n | input | 1 | Asynchronous external interrupt pin, active low |
| tmr_ovf | input | 1 | Timer overflow strobe |
| adc_eoc | input | 1 | A/D end-of-conversion strobe |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| insn_bound | input | 1 | Core is at an instruction boundary |
| stack_full | input | 1 | Core stack has no free entry |
| reti | input | 1 | Core executes return-from-interrupt |
| irq_take | output | 1 | Push PC and jump to irq_vector |
| irq_vector | output | 12 | Vector address of the serviced source |
| pc_pop | output | 1 | Pop the saved PC from the stack |

## Verification
Most faults in the internal state appear on reg_rdata on the next cycle. A master enable that fails to clear shows as 1 in bit 0 right after a take. A flag cleared for the wrong source shows as a different read value. A lost pending request shows as a missing vector when the master enable is set again. A faulty priority or vector table shows on irq_vector in the cycle after the qualifying boundary. A faulty synchronizer or edge detector delays or repeats the external flag by a few cycles. The tests therefore wait several cycles and also recheck the flag while the pin stays low.

// File: rtl/irq_pkg.sv
// Package: shared constants for the interrupt controller.
// Assumes a fixed register layout: master enable, then enables, then flags.
package irq_pkg;
    localparam int NSRC   = 3;
    localparam int REG_W  = 8;
    localparam int B_EMI  = 0;
    localparam int B_EN0  = 1;
    localparam int B_FL0  = B_EN0 + NSRC;
    localparam int B_RSV  = B_FL0 + NSRC;

    typedef enum logic [1:0] {
        SRC_EXT = 2'd0,
        SRC_TMR = 2'd1,
        SRC_ADC = 2'd2
    } src_e;
endpackage

// File: rtl/irq_edge_sync.sv
// Module: synchronizes an asynchronous active-low pin and flags its falling edge.
// Assumes STAGES >= 2. Resets to "pin high" so that leaving reset causes no false edge.
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic [STAGES:0] sh;

    // Shift the pin through the synchronizer and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-1:0], pin_n};
    end

    // Falling edge: older sample high, newer sample low.
    always_comb fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/irq_ctrl_reg.sv
// Module: control register holding master enable, source enables and request flags.
// Assumes hardware set beats clear, and hardware clear beats a software write.
module irq_ctrl_reg
    import irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [N-1:0]     evt,
    input  logic             clr_emi,
    input  logic [N-1:0]     clr_flag,
    output logic             emi,
    output logic [N-1:0]     en,
    output logic [N-1:0]     flag,
    output logic [REG_W-1:0] rdata
);
    localparam int FL0 = B_EN0 + N;
    localparam int USED = FL0 + N;

    logic [N-1:0] flag_base;

    // Value the flags take before hardware clear and set.
    always_comb flag_base = wr ? wdata[FL0 +: N] : flag;

    // Register update: write, then hardware clear, then event set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emi  <= 1'b0;
            en   <= '0;
            flag <= '0;
        end else begin
            emi  <= clr_emi ? 1'b0 : (wr ? wdata[B_EMI] : emi);
            en   <= wr ? wdata[B_EN0 +: N] : en;
            flag <= (flag_base & ~clr_flag) | evt;
        end
    end

    // Read view; unused upper bits read as zero.
    always_comb begin
        rdata = '0;
        rdata[B_EMI]       = emi;
        rdata[B_EN0 +: N]  = en;
        rdata[FL0 +: N]    = flag;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_flag_chk
            p_evt_sets_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
                evt[i] |=> flag[i]);
        end
    endgenerate

    p_hw_clear_emi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_emi |=> !emi);

    p_rsv_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[REG_W-1:USED] == '0);
endmodule

// File: rtl/irq_prio.sv
// Module: fixed-priority selector; the lowest index wins.
// Assumes req is already qualified by enable; purely combinational.
module irq_prio #(
    parameter int N  = 3,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx
);
    // Scan from the highest index down so that the lowest index is kept last.
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                idx = IW'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/mcu_irq_ctrl.sv
// Module: top of the interrupt controller. Latches events, qualifies requests,
// issues a take strobe with a vector, and turns reti into a pop command.
// Assumes the core pushes the PC when it sees irq_take, and reports stack_full.
module mcu_irq_ctrl
    import irq_pkg::*;
#(
    parameter int PC_W     = 12,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_int_n,
    input  logic             tmr_ovf,
    input  logic             adc_eoc,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             insn_bound,
    input  logic             stack_full,
    input  logic             reti,
    output logic             irq_take,
    output logic [PC_W-1:0]  irq_vector,
    output logic             pc_pop
);
    localparam int IW = $clog2(NSRC);

    logic            ext_fall;
    logic [NSRC-1:0] evt, en, flag, req, grant, clr_flag;
    logic            emi, any, take_ok;
    logic [IW-1:0]   idx;

    irq_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_n(ext_int_n), .fall(ext_fall)
    );

    // Event vector, indexed by source priority order.
    always_comb begin
        evt = '0;
        evt[SRC_EXT] = ext_fall;
        evt[SRC_TMR] = tmr_ovf;
        evt[SRC_ADC] = adc_eoc;
    end

    irq_ctrl_reg #(.N(NSRC)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
        .evt(evt), .clr_emi(take_ok), .clr_flag(clr_flag),
        .emi(emi), .en(en), .flag(flag), .rdata(reg_rdata)
    );

    // Qualified requests feed the priority selector.
    always_comb req = flag & en;

    irq_prio #(.N(NSRC), .IW(IW)) u_prio (
        .req(req), .any(any), .grant(grant), .idx(idx)
    );

    // Acceptance condition and the clear for the serviced flag.
    always_comb begin
        take_ok  = emi & any & ~stack_full & insn_bound;
        clr_flag = take_ok ? grant : '0;
    end

    // Register the take strobe, vector and pop command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_take   <= 1'b0;
            irq_vector <= '0;
            pc_pop     <= 1'b0;
        end else begin
            irq_take <= take_ok;
            pc_pop   <= reti;
            if (take_ok)
                irq_vector <= PC_W'(VEC_BASE + VEC_STEP * int'(idx));
        end
    end

    p_take_needs_emi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> $past(emi));
    p_grant_qualified_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~(flag & en)) == '0);
    p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_emi_off_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> !emi);
    p_take_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !irq_take);
    p_no_take_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> !$past(stack_full));
    p_take_at_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> $past(insn_bound));
    p_pop_after_reti_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_pop |-> $past(reti));
endmodule

// File: tb/tb_mcu_irq_ctrl.sv
module tb_mcu_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n, ext_int_n, tmr_ovf, adc_eoc, reg_wr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        insn_bound, stack_full, reti, irq_take, pc_pop;
    logic [11:0] irq_vector;
    int errors = 0;
    int checks = 0;
    logic [7:0] rd;

    always #10 clk = ~clk;

    mcu_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ext_int_n(ext_int_n), .tmr_ovf(tmr_ovf),
        .adc_eoc(adc_eoc), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .insn_bound(insn_bound), .stack_full(stack_full),
        .reti(reti), .irq_take(irq_take), .irq_vector(irq_vector), .pc_pop(pc_pop)
    );

    // [31:24] written value, [23:16] expected read-back, [12] take expected, [11:0] vector
    localparam logic [31:0] TBL [8] = '{
        {8'h7F, 8'h6E, 4'h1, 12'h004},
        {8'h6F, 8'h4E, 4'h1, 12'h008},
        {8'h49, 8'h08, 4'h1, 12'h00C},
        {8'h7E, 8'h7E, 4'h0, 12'h000},
        {8'h71, 8'h71, 4'h0, 12'h000},
        {8'h65, 8'h44, 4'h1, 12'h008},
        {8'hFF, 8'h6E, 4'h1, 12'h004},
        {8'h5B, 8'h4A, 4'h1, 12'h004}
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v; insn_bound = 1'b0;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // Write v with no boundary, then give one boundary cycle; sample after it.
    task automatic apply(input logic [7:0] v);
        wr_reg(v);
        insn_bound = 1'b1;
        @(negedge clk); insn_bound = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; ext_int_n = 1'b1; tmr_ovf = 1'b0; adc_eoc = 1'b0;
        reg_wr = 1'b0; reg_wdata = '0; insn_bound = 1'b0; stack_full = 1'b0; reti = 1'b0;
        repeat (3) @(negedge clk);
        chk(reg_rdata == 8'h00 && !irq_take && !pc_pop, "R1 in reset",
            {reg_rdata, 7'b0, irq_take, 7'b0, pc_pop}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(reg_rdata == 8'h00 && !irq_take, "R1 after reset", reg_rdata, 32'h0);

        // Table walk: R2 R3 R5 R6
        for (int i = 0; i < 8; i++) begin
            apply(TBL[i][31:24]);
            chk(irq_take == TBL[i][12], "R3/R5 take", irq_take, TBL[i][12]);
            if (TBL[i][12])
                chk(irq_vector == TBL[i][11:0], "R5 vector", irq_vector, TBL[i][11:0]);
            chk(reg_rdata == TBL[i][23:16], "R2/R6 readback", reg_rdata, TBL[i][23:16]);
            @(negedge clk);
            chk(!irq_take, "R6 single pulse", irq_take, 0);
            wr_reg(8'h00);
        end

        // R2: reserved bit ignored
        wr_reg(8'h80);
        chk(reg_rdata == 8'h00, "R2 reserved bit", reg_rdata, 8'h00);

        // R4: events set flags with enables off
        @(negedge clk); tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
        chk(reg_rdata == 8'h20, "R4 timer flag", reg_rdata, 8'h20);
        adc_eoc = 1'b1;
        @(negedge clk); adc_eoc = 1'b0;
        chk(reg_rdata == 8'h60, "R4 adc flag", reg_rdata, 8'h60);
        ext_int_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(reg_rdata == 8'h70, "R4 ext edge flag", reg_rdata, 8'h70);
        wr_reg(8'h00);
        repeat (4) @(negedge clk);
        chk(reg_rdata == 8'h00, "R4 held-low pin no re-set", reg_rdata, 8'h00);
        ext_int_n = 1'b1;
        repeat (3) @(negedge clk);

        // R7: pending requests served in order each time the master enable is set again
        wr_reg(8'h7E);
        rd = 8'h7E;
        for (int k = 0; k < 3; k++) begin
            apply(rd | 8'h01);
            chk(irq_take && irq_vector == 12'h004 + 12'(4 * k), "R7 pending order",
                {irq_take, irq_vector}, {1'b1, 12'h004 + 12'(4 * k)});
            rd = reg_rdata;
        end
        chk(reg_rdata == 8'h0E, "R7 all flags consumed", reg_rdata, 8'h0E);

        // R8: stack full blocks, then taken once it clears
        stack_full = 1'b1;
        apply(8'h7F);
        chk(!irq_take && reg_rdata == 8'h7F, "R8 blocked when full",
            {irq_take, reg_rdata}, {1'b0, 8'h7F});
        stack_full = 1'b0;
        insn_bound = 1'b1;
        @(negedge clk); insn_bound = 1'b0;
        chk(irq_take && irq_vector == 12'h004, "R8 taken after full clears",
            {irq_take, irq_vector}, {1'b1, 12'h004});
        wr_reg(8'h00);

        // R9: no boundary, no take
        wr_reg(8'h7F);
        repeat (3) @(negedge clk);
        chk(!irq_take && reg_rdata == 8'h7F, "R9 no boundary",
            {irq_take, reg_rdata}, {1'b0, 8'h7F});
        wr_reg(8'h00);

        // R10: reti -> pc_pop next cycle, one cycle wide
        reti = 1'b1;
        @(negedge clk); reti = 1'b0;
        chk(pc_pop, "R10 pop pulse", pc_pop, 1);
        @(negedge clk);
        chk(!pc_pop, "R10 pop ends", pc_pop, 0);

        // R11: same-cycle event and write, flag ends at 1
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h00; tmr_ovf = 1'b1;
        @(negedge clk); reg_wr = 1'b0; tmr_ovf = 1'b0;
        chk(reg_rdata == 8'h20, "R11 event beats write", reg_rdata, 8'h20);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule